// File: doc/BRIEF.md
# Field Video DMA Address Generator

This block is one channel of a video DMA engine. It moves one field of pixel data at a time between a local dword FIFO and system memory, and it produces the memory address, byte enables and (when writing) the data of each dword. A field begins with a pulse on `field_start` together with the parity of the field. The parity picks one of two programmed base addresses. From there the channel walks the field line by line, and each line start is separated from the next by a programmable pitch. When vertical flip is selected, the base names the lower-left pixel and the channel walks the lines upward.

The line and byte counts are programmed minus one. In read mode, the channel issues memory reads on its own until the whole field is requested, and returned data is byte-swapped on its way back to the FIFO. In write mode, the channel takes dwords from the FIFO, which marks each input line end. It writes only the programmed number of bytes per line and the programmed number of lines, and it silently consumes any surplus. Every candidate address is compared with a protection address, and a mode field decides whether a crossing is ignored, only flagged, or also shuts the channel for the rest of the field. Configuration writes land in holding registers and only become active at the next field start.

Top module: `vdma_field_agen`

## Requirements
- R1: After reset, `req_valid`, `out_valid` and `prot_err` are 0 and `fifo_ready` is 1, so FIFO input is drained before the first field.
- R2: Every write dword is byte-swapped by the swap field (control register bits [3:2]). With input bytes b3 b2 b1 b0 (b3 in bits [31:24]), mode 0 gives b3 b2 b1 b0, mode 1 gives b2 b3 b0 b1, mode 2 gives b0 b1 b2 b3, and mode 3 behaves as mode 0.
- R3: Data on `rsp_data` with `rsp_valid` appears on `out_data` with `out_valid` one clock later, swapped by the same swap field.
- R4: The first dword of a field goes to the odd-field base (register 2) when `field_odd` was 1 at the field start, and to the even-field base (register 3) when it was 0.
- R5: Within a line, successive dwords are 4 bytes apart. Without flip, line n starts at base + n*pitch, where pitch is register 4.
- R6: With flip (control bit 1) set, line n starts at base - n*pitch.
- R7: The geometry register holds lines-1 in bits [11:0] and bytes-1 in bits [27:16]. A line has ceil(bytes/4) dwords. The last dword enables only the remaining low lanes (1 byte: 0001, 2: 0011, 3: 0111), and all other dwords enable 1111.
- R8: In write mode (control bit 0 = 0), FIFO dwords past the byte count of a line are accepted with no memory request. A dword with `fifo_eol` set ends the input line.
- R9: In write mode, input lines past the line count are accepted and dropped until the next field start. In read mode, exactly lines*dwords requests are issued and then the channel stops.
- R10: The protection mode (control bits [5:4]) controls the address check. Mode 0 disables it. With mode 1, a dword whose address is at or above the protection address (register 5) is still issued, and it sets `prot_err`. With mode 2 or 3, that dword and every later request of the field are suppressed, and `prot_err` is set. `prot_err` stays set until the next field start, which clears it.
- R11: Register writes change nothing in a field in progress. They take effect at the next field start.
- R12: `req_write` is 1 in write mode and 0 in read mode, and `fifo_ready` is 0 throughout read mode.
- R13: A request held with `req_ready` low keeps its address, data and enables unchanged until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Register index: 0 control, 1 geometry, 2 odd base, 3 even base, 4 pitch, 5 protection address |
| cfg_wdata | input | 32 | Configuration write data |
| field_start | input | 1 | Pulse that starts a field and loads the held configuration |
| field_odd | input | 1 | Parity of the starting field, 1 = odd |
| fifo_valid | input | 1 | FIFO-side dword valid (write mode) |
| fifo_data | input | 32 | FIFO-side dword |
| fifo_eol | input | 1 | Marks the last dword of an input line |
| fifo_ready | output | 1 | Channel accepts the FIFO-side dword |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory side takes the request |
| req_write | output | 1 | 1 = write to memory, 0 = read from memory |
| req_addr | output | 32 | Dword byte address |
| req_be | output | 4 | Byte lane enables, lane 0 = bits [7:0] |
| req_data | output | 32 | Swapped write data |
| rsp_valid | input | 1 | Read data returned from memory |
| rsp_data | input | 32 | Returned dword |
| out_valid | output | 1 | Swapped read data valid toward the FIFO |
| out_data | output | 32 | Swapped read data |
| prot_err | output | 1 | Sticky protection violation flag for the current field |

## Verification
The hardest case to reach is a protection crossing in the middle of a field. There the violating dword must be issued or withheld according to the mode, while the rest of the field keeps flowing or stops. The bench reaches it by placing the protection address on the second dword of the second line of an even field. It then pushes whole input lines, plus a further line after the crossing, and compares the captured request stream and the flag under each mode. Line clipping and the flip walk are reached the same way: the bench pushes input lines longer than the programmed count and more lines than the programmed field.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] REG_CTRL     = 3'd0;
    localparam logic [REG_AW-1:0] REG_GEOM     = 3'd1;
    localparam logic [REG_AW-1:0] REG_BASE_ODD = 3'd2;
    localparam logic [REG_AW-1:0] REG_BASE_EVN = 3'd3;
    localparam logic [REG_AW-1:0] REG_PITCH    = 3'd4;
    localparam logic [REG_AW-1:0] REG_PROT     = 3'd5;

    // control register bit positions
    localparam int CTRL_DIR   = 0;
    localparam int CTRL_FLIP  = 1;
    localparam int CTRL_SWAP  = 2;
    localparam int CTRL_PMODE = 4;

    // geometry register field positions
    localparam int GEOM_LINE_LSB = 0;
    localparam int GEOM_BYTE_LSB = 16;

    localparam int DWORD_W = 32;
    localparam int LANES   = DWORD_W / 8;

    typedef enum logic [1:0] {
        SWAP_NONE = 2'd0,
        SWAP_HALF = 2'd1,
        SWAP_FULL = 2'd2,
        SWAP_RSVD = 2'd3
    } swap_e;

    typedef enum logic [1:0] {
        PROT_OFF    = 2'd0,
        PROT_FLAG   = 2'd1,
        PROT_STOP   = 2'd2,
        PROT_STOP_B = 2'd3
    } prot_e;

endpackage

// File: rtl/vdma_cfg_regs.sv
module vdma_cfg_regs
    import vdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [AW-1:0]     wdata,
    output logic              dir,
    output logic              flip,
    output logic [1:0]        swap,
    output logic [1:0]        pmode,
    output logic [CW-1:0]     nlines,
    output logic [CW-1:0]     nbytes,
    output logic [AW-1:0]     base_odd,
    output logic [AW-1:0]     base_even,
    output logic [AW-1:0]     pitch,
    output logic [AW-1:0]     prot
);

    typedef struct packed {
        logic          dir;
        logic          flip;
        logic [1:0]    swap;
        logic [1:0]    pmode;
        logic [CW-1:0] nlines;
        logic [CW-1:0] nbytes;
        logic [AW-1:0] base_odd;
        logic [AW-1:0] base_even;
        logic [AW-1:0] pitch;
        logic [AW-1:0] prot;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            unique case (addr)
                REG_CTRL: begin
                    cfg_d.dir   = wdata[CTRL_DIR];
                    cfg_d.flip  = wdata[CTRL_FLIP];
                    cfg_d.swap  = wdata[CTRL_SWAP +: 2];
                    cfg_d.pmode = wdata[CTRL_PMODE +: 2];
                end
                REG_GEOM: begin
                    cfg_d.nlines = wdata[GEOM_LINE_LSB +: CW];
                    cfg_d.nbytes = wdata[GEOM_BYTE_LSB +: CW];
                end
                REG_BASE_ODD: cfg_d.base_odd  = wdata;
                REG_BASE_EVN: cfg_d.base_even = wdata;
                REG_PITCH:    cfg_d.pitch     = wdata;
                REG_PROT:     cfg_d.prot      = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign dir       = cfg_q.dir;
    assign flip      = cfg_q.flip;
    assign swap      = cfg_q.swap;
    assign pmode     = cfg_q.pmode;
    assign nlines    = cfg_q.nlines;
    assign nbytes    = cfg_q.nbytes;
    assign base_odd  = cfg_q.base_odd;
    assign base_even = cfg_q.base_even;
    assign pitch     = cfg_q.pitch;
    assign prot      = cfg_q.prot;

endmodule

// File: rtl/vdma_swap.sv
module vdma_swap
    import vdma_pkg::*;
(
    input  logic [DWORD_W-1:0] din,
    input  logic [1:0]         mode,
    output logic [DWORD_W-1:0] dout
);

    logic [7:0] lane [LANES];
    logic [DWORD_W-1:0] half_sw;
    logic [DWORD_W-1:0] full_sw;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = din[8*g +: 8];
        // swap neighbours inside each 16-bit half
        assign half_sw[8*g +: 8] = lane[g ^ 1];
        // mirror the lanes across the dword
        assign full_sw[8*g +: 8] = lane[LANES-1-g];
    end

    always_comb begin
        unique case (swap_e'(mode))
            SWAP_HALF: dout = half_sw;
            SWAP_FULL: dout = full_sw;
            default:   dout = din;
        endcase
    end

endmodule

// File: rtl/vdma_prot.sv
module vdma_prot
    import vdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] limit,
    input  logic [1:0]    mode,
    output logic          viol,
    output logic          stop
);

    logic crossed;

    assign crossed = addr >= limit;
    assign viol    = (prot_e'(mode) != PROT_OFF) && crossed;
    assign stop    = viol && mode[1];

endmodule

// File: rtl/vdma_field_agen.sv
module vdma_field_agen
    import vdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [REG_AW-1:0]  cfg_addr,
    input  logic [AW-1:0]      cfg_wdata,
    input  logic               field_start,
    input  logic               field_odd,
    input  logic               fifo_valid,
    input  logic [DWORD_W-1:0] fifo_data,
    input  logic               fifo_eol,
    output logic               fifo_ready,
    output logic               req_valid,
    input  logic               req_ready,
    output logic               req_write,
    output logic [AW-1:0]      req_addr,
    output logic [LANES-1:0]   req_be,
    output logic [DWORD_W-1:0] req_data,
    input  logic               rsp_valid,
    input  logic [DWORD_W-1:0] rsp_data,
    output logic               out_valid,
    output logic [DWORD_W-1:0] out_data,
    output logic               prot_err
);

    localparam int TW = CW + 1;   // byte total per line, 1..2**CW
    localparam int PW = CW + 2;   // byte position, may overshoot by 3
    localparam logic [PW-1:0] STEP = PW'(LANES);

    // held configuration
    logic          c_dir, c_flip;
    logic [1:0]    c_swap, c_pmode;
    logic [CW-1:0] c_nlines, c_nbytes;
    logic [AW-1:0] c_base_odd, c_base_even, c_pitch, c_prot;

    vdma_cfg_regs #(.AW(AW), .CW(CW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .dir       (c_dir),
        .flip      (c_flip),
        .swap      (c_swap),
        .pmode     (c_pmode),
        .nlines    (c_nlines),
        .nbytes    (c_nbytes),
        .base_odd  (c_base_odd),
        .base_even (c_base_even),
        .pitch     (c_pitch),
        .prot      (c_prot)
    );

    // field state, frozen copy of configuration plus walk position
    typedef struct packed {
        logic               active;
        logic               dir;
        logic               flip;
        logic [1:0]         swap;
        logic [1:0]         pmode;
        logic [CW-1:0]      nlines;
        logic [TW-1:0]      total;
        logic [AW-1:0]      pitch;
        logic [AW-1:0]      prot;
        logic [AW-1:0]      line_addr;
        logic [AW-1:0]      cur_addr;
        logic [PW-1:0]      bpos;
        logic [CW-1:0]      lidx;
        logic               perr;
        logic               req_valid;
        logic               req_write;
        logic [AW-1:0]      req_addr;
        logic [LANES-1:0]   req_be;
        logic [DWORD_W-1:0] req_data;
        logic               out_valid;
        logic [DWORD_W-1:0] out_data;
    } st_t;

    st_t st_d, st_q;

    // datapath helpers
    logic [DWORD_W-1:0] wr_swapped, rd_swapped;
    logic               viol, stop;
    logic [PW-1:0]      total_x, rem, bpos_nx;
    logic               in_line, last_dw, last_line, slot_free;
    logic [AW-1:0]      next_line;
    logic [LANES-1:0]   be_c;

    vdma_swap u_swap_wr (.din(fifo_data), .mode(st_q.swap), .dout(wr_swapped));
    vdma_swap u_swap_rd (.din(rsp_data),  .mode(st_q.swap), .dout(rd_swapped));

    vdma_prot #(.AW(AW)) u_prot (
        .addr  (st_q.cur_addr),
        .limit (st_q.prot),
        .mode  (st_q.pmode),
        .viol  (viol),
        .stop  (stop)
    );

    assign total_x   = PW'(st_q.total);
    assign in_line   = st_q.bpos < total_x;
    assign rem       = total_x - st_q.bpos;
    assign bpos_nx   = st_q.bpos + STEP;
    assign last_dw   = bpos_nx >= total_x;
    assign last_line = st_q.lidx == st_q.nlines;
    assign slot_free = !st_q.req_valid || req_ready;
    assign next_line = st_q.flip ? (st_q.line_addr - st_q.pitch)
                                 : (st_q.line_addr + st_q.pitch);

    always_comb begin
        if (rem >= STEP) begin
            be_c = '1;
        end else begin
            unique case (rem[1:0])
                2'd1:    be_c = 4'b0001;
                2'd2:    be_c = 4'b0011;
                2'd3:    be_c = 4'b0111;
                default: be_c = '1;
            endcase
        end
    end

    // write mode: surplus and idle input is drained, payload waits for the slot
    assign fifo_ready = !st_q.dir && (!st_q.active || !in_line || slot_free);

    function automatic st_t close_line(st_t s);
        st_t r = s;
        if (last_line) begin
            r.active = 1'b0;
        end else begin
            r.lidx      = s.lidx + 1'b1;
            r.line_addr = next_line;
            r.cur_addr  = next_line;
            r.bpos      = '0;
        end
        return r;
    endfunction

    function automatic st_t issue(st_t s, logic wr, logic [DWORD_W-1:0] d);
        st_t r = s;
        r.req_valid = 1'b1;
        r.req_write = wr;
        r.req_addr  = s.cur_addr;
        r.req_be    = be_c;
        r.req_data  = d;
        r.cur_addr  = s.cur_addr + AW'(LANES);
        r.bpos      = bpos_nx;
        if (viol) r.perr = 1'b1;
        return r;
    endfunction

    always_comb begin
        st_d = st_q;

        if (st_q.req_valid && req_ready) st_d.req_valid = 1'b0;

        if (st_q.active && !st_q.dir) begin
            if (fifo_valid && fifo_ready) begin
                if (in_line && stop) begin
                    st_d.perr   = 1'b1;
                    st_d.active = 1'b0;
                end else begin
                    if (in_line) st_d = issue(st_d, 1'b1, wr_swapped);
                    if (fifo_eol) st_d = close_line(st_d);
                end
            end
        end else if (st_q.active && st_q.dir) begin
            if (slot_free) begin
                if (stop) begin
                    st_d.perr   = 1'b1;
                    st_d.active = 1'b0;
                end else begin
                    st_d = issue(st_d, 1'b0, '0);
                    if (last_dw) st_d = close_line(st_d);
                end
            end
        end

        // returning read data
        st_d.out_valid = rsp_valid;
        if (rsp_valid) st_d.out_data = rd_swapped;

        // a new field overrides the walk and loads the held configuration
        if (field_start) begin
            st_d.active    = 1'b1;
            st_d.dir       = c_dir;
            st_d.flip      = c_flip;
            st_d.swap      = c_swap;
            st_d.pmode     = c_pmode;
            st_d.nlines    = c_nlines;
            st_d.total     = TW'(c_nbytes) + TW'(1);
            st_d.pitch     = c_pitch;
            st_d.prot      = c_prot;
            st_d.line_addr = field_odd ? c_base_odd : c_base_even;
            st_d.cur_addr  = field_odd ? c_base_odd : c_base_even;
            st_d.bpos      = '0;
            st_d.lidx      = '0;
            st_d.perr      = 1'b0;
            st_d.req_valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_valid = st_q.req_valid;
    assign req_write = st_q.req_write;
    assign req_addr  = st_q.req_addr;
    assign req_be    = st_q.req_be;
    assign req_data  = st_q.req_data;
    assign out_valid = st_q.out_valid;
    assign out_data  = st_q.out_data;
    assign prot_err  = st_q.perr;

endmodule

// File: rtl/vdma_field_agen_chk.sv
module vdma_field_agen_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          field_start,
    input logic          req_valid,
    input logic          req_ready,
    input logic          req_write,
    input logic [AW-1:0] req_addr,
    input logic [3:0]    req_be,
    input logic [31:0]   req_data,
    input logic          rsp_valid,
    input logic          out_valid,
    input logic          prot_err,
    input logic          dir_s
);

    assert_hold_req_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !field_start) |=>
            (req_valid && $stable(req_addr) && $stable(req_be) && $stable(req_data)));

    assert_be_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((req_be != 4'd0) && ((req_be & (req_be + 4'd1)) == 4'd0)));

    assert_perr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_err && !field_start) |=> prot_err);

    assert_perr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> !prot_err);

    assert_dir_match_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_write == !dir_s));

    assert_rsp_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> out_valid);

    assert_rsp_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |=> !out_valid);

endmodule

bind vdma_field_agen vdma_field_agen_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .field_start (field_start),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_be      (req_be),
    .req_data    (req_data),
    .rsp_valid   (rsp_valid),
    .out_valid   (out_valid),
    .prot_err    (prot_err),
    .dir_s       (st_q.dir)
);

// File: tb/vdma_field_agen_bench.sv
module vdma_field_agen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        field_start = 1'b0, field_odd = 1'b0;
    logic        fifo_valid = 1'b0, fifo_eol = 1'b0;
    logic [31:0] fifo_data = '0;
    logic        fifo_ready;
    logic        req_valid, req_write;
    logic        req_ready = 1'b1;
    logic [31:0] req_addr, req_data;
    logic [3:0]  req_be;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        prot_err;

    always #2.5 clk = ~clk;

    vdma_field_agen u_vdma_field_agen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .field_start(field_start), .field_odd(field_odd),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_eol(fifo_eol),
        .fifo_ready(fifo_ready), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
        .req_data(req_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .out_valid(out_valid), .out_data(out_data), .prot_err(prot_err)
    );

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // captured requests, sampled at the falling edge before the taking edge
    int          ncap = 0;
    logic [31:0] ca [64];
    logic [31:0] cd [64];
    logic [3:0]  cb [64];
    logic        cw [64];

    always @(negedge clk) begin
        if (rst_n && req_valid && req_ready && ncap < 64) begin
            ca[ncap] = req_addr;
            cd[ncap] = req_data;
            cb[ncap] = req_be;
            cw[ncap] = req_write;
            ncap = ncap + 1;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 100000) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not end, actual=%0d expected<%0d cycles", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic fstart(input logic odd);
        @(posedge clk); #1;
        field_start = 1'b1; field_odd = odd;
        @(posedge clk); #1;
        field_start = 1'b0;
    endtask

    task automatic push(input logic [31:0] d, input logic eol);
        @(posedge clk); #1;
        fifo_valid = 1'b1; fifo_data = d; fifo_eol = eol;
        @(negedge clk);
        while (!fifo_ready) @(negedge clk);
        @(posedge clk); #1;
        fifo_valid = 1'b0; fifo_eol = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clr();
        @(posedge clk); #1;
        ncap = 0;
    endtask

    // {swap mode, input dword, expected request data}
    localparam logic [65:0] SWV [6] = '{
        {2'd0, 32'h44332211, 32'h44332211},
        {2'd1, 32'h44332211, 32'h33441122},
        {2'd2, 32'h44332211, 32'h11223344},
        {2'd3, 32'h44332211, 32'h44332211},
        {2'd1, 32'hA1B2C3D4, 32'hB2A1D4C3},
        {2'd2, 32'hA1B2C3D4, 32'hD4C3B2A1}
    };

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R1 reset state
        check(req_valid == 1'b0, "R1 req_valid", {31'd0, req_valid}, 0);
        check(out_valid == 1'b0, "R1 out_valid", {31'd0, out_valid}, 0);
        check(prot_err == 1'b0,  "R1 prot_err",  {31'd0, prot_err}, 0);
        check(fifo_ready == 1'b1, "R1 fifo_ready", {31'd0, fifo_ready}, 1);
        rst_n = 1'b1;

        // table walk: R2 swap modes and R12 write direction
        wr(3'd1, (32'd3 << 16) | 32'd0);
        wr(3'd2, 32'h0000_1000);
        wr(3'd4, 32'h0000_0100);
        wr(3'd5, 32'hFFFF_FFF0);
        for (int i = 0; i < 6; i++) begin
            clr();
            wr(3'd0, {28'd0, SWV[i][65:64], 2'b00});
            fstart(1'b1);
            push(SWV[i][63:32], 1'b1);
            settle(3);
            check(ncap == 1 && cd[0] == SWV[i][31:0], "R2 swap data", cd[0], SWV[i][31:0]);
            check(cw[0] == 1'b1 && ca[0] == 32'h1000, "R12 write dir / R4 odd base", ca[0], 32'h1000);
        end

        // R4 even base, R5 pitch, R7 partial enables, R8 byte clip, R9 line clip
        wr(3'd0, 32'd0);
        wr(3'd1, (32'd5 << 16) | 32'd1);
        wr(3'd3, 32'h0000_2000);
        wr(3'd4, 32'h0000_0100);
        clr();
        fstart(1'b0);
        push(32'hD0, 1'b0); push(32'hD1, 1'b0); push(32'hD2, 1'b1);
        push(32'hD3, 1'b0); push(32'hD4, 1'b0); push(32'hD5, 1'b1);
        push(32'hD6, 1'b0); push(32'hD7, 1'b1);
        settle(3);
        check(ncap == 4, "R8 R9 request count after clipping", ncap, 4);
        check(ca[0] == 32'h2000 && cb[0] == 4'hF, "R4 even base first dword", ca[0], 32'h2000);
        check(ca[1] == 32'h2004 && cb[1] == 4'h3 && cd[1] == 32'hD1, "R7 partial dword 0011", {ca[1][27:0], cb[1]}, {28'h2004, 4'h3});
        check(ca[2] == 32'h2100 && cd[2] == 32'hD3, "R5 second line start", ca[2], 32'h2100);
        check(ca[3] == 32'h2104 && cb[3] == 4'h3, "R5 second line step", ca[3], 32'h2104);

        // R6 flip in read mode, R7 dword count and 0001 tail, R9 read stops, R12
        wr(3'd0, 32'h3);
        wr(3'd1, (32'd8 << 16) | 32'd2);
        wr(3'd2, 32'h0000_8000);
        wr(3'd4, 32'h0000_0040);
        clr();
        fstart(1'b1);
        settle(2);
        check(fifo_ready == 1'b0, "R12 fifo_ready low in read mode", {31'd0, fifo_ready}, 0);
        settle(30);
        check(ncap == 9, "R9 read request count", ncap, 9);
        for (int l = 0; l < 3; l++) begin
            for (int k = 0; k < 3; k++) begin
                check(ca[3*l+k] == 32'h8000 - 32'h40*l + 4*k && cw[3*l+k] == 1'b0,
                      "R6 flip address", ca[3*l+k], 32'h8000 - 32'h40*l + 4*k);
            end
        end
        check(cb[2] == 4'h1 && cb[1] == 4'hF, "R7 one byte tail", {28'd0, cb[2]}, 1);

        // R7 minus-one encoding: zero means one byte
        wr(3'd1, 32'd0);
        clr();
        fstart(1'b1);
        settle(8);
        check(ncap == 1 && cb[0] == 4'h1, "R7 single byte field", ncap, 1);
        wr(3'd1, 32'd2 << 16);
        clr();
        fstart(1'b1);
        settle(8);
        check(ncap == 1 && cb[0] == 4'h7, "R7 three byte line", {28'd0, cb[0]}, 7);

        // R3 read data path with full swap
        wr(3'd0, 32'h9);
        fstart(1'b1);
        @(posedge clk); #1;
        rsp_valid = 1'b1; rsp_data = 32'h0A0B0C0D;
        @(negedge clk);
        check(out_valid == 1'b0, "R3 not before one clock", {31'd0, out_valid}, 0);
        @(posedge clk); #1;
        rsp_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b1 && out_data == 32'h0D0C0B0A, "R3 swapped read data", out_data, 32'h0D0C0B0A);
        settle(2);
        check(out_valid == 1'b0, "R3 valid drops", {31'd0, out_valid}, 0);

        // R10 flag-only mode
        wr(3'd0, 32'h10);
        wr(3'd1, (32'd7 << 16) | 32'd3);
        wr(3'd3, 32'h0000_2000);
        wr(3'd4, 32'h0000_0100);
        wr(3'd5, 32'h0000_2104);
        clr();
        fstart(1'b0);
        push(32'h1, 1'b0); push(32'h2, 1'b1);
        settle(3);
        check(prot_err == 1'b0, "R10 no crossing yet", {31'd0, prot_err}, 0);
        push(32'h3, 1'b0); push(32'h4, 1'b1);
        settle(3);
        check(ncap == 4 && ca[3] == 32'h2104, "R10 flag mode still issues", ncap, 4);
        check(prot_err == 1'b1, "R10 flag set", {31'd0, prot_err}, 1);
        settle(5);
        check(prot_err == 1'b1, "R10 flag sticky", {31'd0, prot_err}, 1);
        fstart(1'b0);
        settle(1);
        check(prot_err == 1'b0, "R10 cleared at field start", {31'd0, prot_err}, 0);

        // R10 stop mode: crossing dword and rest of field suppressed
        wr(3'd0, 32'h20);
        clr();
        fstart(1'b0);
        push(32'h1, 1'b0); push(32'h2, 1'b1);
        push(32'h3, 1'b0); push(32'h4, 1'b1);
        push(32'h5, 1'b1);
        settle(3);
        check(ncap == 3 && prot_err == 1'b1, "R10 stop mode suppresses", ncap, 3);

        // R10 check disabled
        wr(3'd0, 32'h0);
        wr(3'd5, 32'h0000_2000);
        clr();
        fstart(1'b0);
        push(32'h1, 1'b0); push(32'h2, 1'b1);
        settle(3);
        check(ncap == 2 && prot_err == 1'b0, "R10 mode off ignores limit", ncap, 2);

        // R11 writes wait for the next field
        wr(3'd5, 32'hFFFF_FFF0);
        wr(3'd1, (32'd3 << 16) | 32'd3);
        wr(3'd2, 32'h0000_3000);
        wr(3'd4, 32'h0000_0100);
        clr();
        fstart(1'b1);
        push(32'h11, 1'b1);
        wr(3'd2, 32'h0000_5000);
        wr(3'd4, 32'h0000_0010);
        push(32'h12, 1'b1);
        settle(3);
        check(ncap == 2 && ca[1] == 32'h3100, "R11 mid-field write ignored", ca[1], 32'h3100);
        clr();
        fstart(1'b1);
        push(32'h13, 1'b1);
        push(32'h14, 1'b1);
        settle(3);
        check(ca[0] == 32'h5000 && ca[1] == 32'h5010, "R11 new field uses new values", ca[1], 32'h5010);

        // R13 back-pressure in read mode
        wr(3'd0, 32'h1);
        wr(3'd1, (32'd7 << 16) | 32'd1);
        wr(3'd2, 32'h0000_0100);
        wr(3'd4, 32'h0000_0020);
        clr();
        req_ready = 1'b0;
        fstart(1'b1);
        settle(5);
        check(req_valid == 1'b1 && req_addr == 32'h100 && ncap == 0, "R13 request waits", req_addr, 32'h100);
        settle(3);
        check(req_addr == 32'h100 && req_be == 4'hF, "R13 request held stable", req_addr, 32'h100);
        req_ready = 1'b1;
        settle(10);
        check(ncap == 4 && ca[1] == 32'h104 && ca[2] == 32'h120 && ca[3] == 32'h124,
              "R13 stream after release", ca[3], 32'h124);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule